// File: doc/BRIEF.md
# Watchdog Timer With Dual Clear

This block is a software-failure watchdog. It counts ticks from one of two sources: an enable pulse from a dedicated slow oscillator, or the instruction clock, which runs at a quarter of the system clock and is made inside the block. The count passes through a fixed divide-by-256 prescaler and then a post divider. A two-bit option picks the stage of the post divider at which a time-out fires. When the chain overflows, the block raises a one-cycle time-out pulse and sets the time-out flag. It also requests a reset: a full chip reset in normal running, or a warm reset (program counter and stack pointer only) while the core is halted.

Software keeps the watchdog quiet with clear strobes. In single-clear mode one strobe is enough. In dual-clear mode two different strobes must both arrive, in either order, before the clear takes effect. A clear zeroes only the two top stages of the selected chain, so the time left after a clear depends on the count already held below them. The halt strobe clears the watchdog the same way and records power-down. An external reset strobe zeroes the whole chain. When the enable option is off, the block ignores every input.

Top module: `wdog_dualclr`

## Requirements
- R1: After rst_n is released, flag_to, flag_pd, tmo_pulse, chip_rst_req and warm_rst_req are all 0, and the chain starts from zero.
- R2: With cfg_src=0 the chain counts each clock cycle where osc_tick=1. With cfg_src=1 it counts one tick per four clock cycles; the tick falls on every 4th rising edge after rst_n is released.
- R3: From a zeroed chain, the time-out fires on the 2^(13+cfg_tsel) th counted tick (cfg_tsel 0..3). This figure includes the fixed 256 prescaler.
- R4: A clear zeroes chain bits 12+cfg_tsel and 11+cfg_tsel and all bits above them, leaves the lower bits alone, and drops any tick in the same cycle. The next time-out then needs 2^(13+sel) minus (held count mod 2^(11+sel)) ticks.
- R5: With cfg_dual=0, clr_single clears the chain and clears both flag_to and flag_pd; clr_one and clr_two have no effect.
- R6: With cfg_dual=1, clr_one and clr_two each stay armed until the other arrives. The pair clears the chain and both flags, then disarms both. clr_single has no effect.
- R7: A time-out gives a tmo_pulse one cycle wide in the cycle after the overflowing tick, sets flag_to, and restarts the chain from zero.
- R8: A time-out with halted=0 gives chip_rst_req, and with halted=1 gives warm_rst_req. Either request is a pulse in the same cycle as tmo_pulse, and the two never occur together.
- R9: halt_cmd clears the chain as in R4, sets flag_pd and clears flag_to.
- R10: With cfg_src=1, no ticks are counted while halted=1. With cfg_src=0, counting goes on while halted.
- R11: With cfg_en=0, the chain holds its value, the flags do not change, every strobe is ignored and no pulse is produced.
- R12: ext_rst zeroes the whole chain, drops any tick in that cycle and disarms pending dual clears; flag_to and flag_pd keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| cfg_en | input | 1 | Watchdog enable option |
| cfg_src | input | 1 | Tick source: 0 slow oscillator, 1 instruction clock |
| cfg_tsel | input | 2 | Time-out stage select |
| cfg_dual | input | 1 | 1 selects dual-clear mode |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator |
| halted | input | 1 | Core is in halt state |
| clr_single | input | 1 | Single-clear instruction strobe |
| clr_one | input | 1 | First dual-clear instruction strobe |
| clr_two | input | 1 | Second dual-clear instruction strobe |
| halt_cmd | input | 1 | Halt instruction strobe |
| ext_rst | input | 1 | External reset strobe |
| tmo_pulse | output | 1 | Time-out pulse |
| chip_rst_req | output | 1 | Full chip reset request |
| warm_rst_req | output | 1 | Warm reset request |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-down status flag |

## Verification
The chain count is internal, so a wrong value shows up only in the exact cycle of the next tmo_pulse. That can be thousands of cycles after the fault, so every time-out is scored to the exact cycle against a figure worked out from the tick history. A lost or stuck dual-clear arm shows up at once on flag_pd: after a halt sets it, only a completed pair may drop it. A wrong halt gate on the instruction clock shifts the time-out by exactly four cycles per stalled tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic {
      SRC_OSC   = 1'b0,
      SRC_INSTR = 1'b1
   } wdog_src_e;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
   import wdog_pkg::*;
#(
   parameter int DIV_BITS = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  wdog_src_e src,
   input  logic      osc_tick,
   input  logic      halted,
   output logic      tick
);
   logic instr_tick;

   generate
      if (DIV_BITS < 0) begin : g_bad_div
         $error("wdog_tick_sel: DIV_BITS must not be negative");
      end
      if (DIV_BITS == 0) begin : g_nodiv
         assign instr_tick = 1'b1;
      end else begin : g_div
         logic [DIV_BITS-1:0] phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phase <= '0;
            else        phase <= phase + 1'b1;
         end
         assign instr_tick = &phase;

         // R2
         instr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && src == SRC_INSTR) ##1 (src == SRC_INSTR) |-> !tick);
      end
   endgenerate

   always_comb begin
      if (src == SRC_INSTR) tick = instr_tick & ~halted;
      else                  tick = osc_tick;
   end
endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic dual,
   input  logic clr_single,
   input  logic clr_one,
   input  logic clr_two,
   input  logic ext_rst,
   output logic clr_go
);
   logic arm1, arm2;
   logic got1, got2, pair;

   assign got1 = arm1 | clr_one;
   assign got2 = arm2 | clr_two;
   assign pair = en & dual & got1 & got2;
   assign clr_go = dual ? pair : (en & clr_single);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm1 <= 1'b0;
         arm2 <= 1'b0;
      end else if (en && (ext_rst || pair)) begin
         arm1 <= 1'b0;
         arm2 <= 1'b0;
      end else if (en && dual) begin
         arm1 <= got1;
         arm2 <= got2;
      end
   end

   // R6
   arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1 && !clr_go && !(en && ext_rst)) |=> arm1);
   // R6
   single_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dual && clr_single && !clr_one && !clr_two && !arm1 && !arm2) |-> !clr_go);
endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
   parameter int PRE_BITS  = 8,
   parameter int POST_BITS = 8,
   parameter int TAP_LOW   = 12,
   parameter int SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   input  logic             clr_part,
   input  logic             clr_full,
   output logic             wrap
);
   localparam int NSEL    = 1 << SEL_W;
   localparam int CHAIN_W = PRE_BITS + POST_BITS;

   generate
      if (TAP_LOW - 1 < PRE_BITS) begin : g_bad_tap
         $error("wdog_chain: cleared stages must lie above the prescaler");
      end
      if (TAP_LOW + NSEL > CHAIN_W) begin : g_bad_len
         $error("wdog_chain: chain too short for the largest tap");
      end
   endgenerate

   logic [PRE_BITS-1:0]  pre;
   logic [POST_BITS-1:0] post;
   logic [NSEL-1:0]      term;
   logic [POST_BITS-1:0] keep [NSEL];
   logic [CHAIN_W-1:0]   inc;

   genvar g;
   generate
      for (g = 0; g < NSEL; g++) begin : g_tap
         localparam int TOP = TAP_LOW + g - PRE_BITS;
         assign term[g] = (&pre) & (&post[TOP:0]);
         assign keep[g] = (POST_BITS'(1) << (TOP - 1)) - POST_BITS'(1);
      end
   endgenerate

   assign inc  = {post, pre} + CHAIN_W'(1);
   assign wrap = en & tick & ~clr_part & ~clr_full & term[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre  <= '0;
         post <= '0;
      end else if (en) begin
         if (clr_full) begin
            pre  <= '0;
            post <= '0;
         end else if (clr_part) begin
            post <= post & keep[sel];
         end else if (tick) begin
            if (term[sel]) begin
               pre  <= '0;
               post <= '0;
            end else begin
               {post, pre} <= inc;
            end
         end
      end
   end

   // R11
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(pre) && $stable(post)));
   // R4
   prescaler_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clr_part && !clr_full) |=> $stable(pre));
   // R12
   full_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clr_full) |=> (pre == '0 && post == '0));
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic halted,
   input  logic wrap,
   input  logic clr_sw,
   input  logic halt_cmd,
   output logic tmo_pulse,
   output logic chip_rst_req,
   output logic warm_rst_req,
   output logic flag_to,
   output logic flag_pd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_pulse    <= 1'b0;
         chip_rst_req <= 1'b0;
         warm_rst_req <= 1'b0;
         flag_to      <= 1'b0;
         flag_pd      <= 1'b0;
      end else begin
         tmo_pulse    <= wrap;
         chip_rst_req <= wrap & ~halted;
         warm_rst_req <= wrap & halted;
         if (en) begin
            if (halt_cmd) begin
               flag_pd <= 1'b1;
               flag_to <= 1'b0;
            end else if (clr_sw) begin
               flag_pd <= 1'b0;
               flag_to <= 1'b0;
            end
            if (wrap) flag_to <= 1'b1;
         end
      end
   end

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |=> !tmo_pulse);
   // R7
   to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_to) |-> tmo_pulse);
   // R8
   one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> (chip_rst_req != warm_rst_req));
   // R9
   halt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && halt_cmd) |=> (flag_pd && !flag_to));
endmodule

// File: rtl/wdog_dualclr.sv
module wdog_dualclr
   import wdog_pkg::*;
#(
   parameter int PRE_BITS  = 8,
   parameter int POST_BITS = 8,
   parameter int TAP_LOW   = 12,
   parameter int SEL_W     = 2,
   parameter int DIV_BITS  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_src,
   input  logic [SEL_W-1:0] cfg_tsel,
   input  logic             cfg_dual,
   input  logic             osc_tick,
   input  logic             halted,
   input  logic             clr_single,
   input  logic             clr_one,
   input  logic             clr_two,
   input  logic             halt_cmd,
   input  logic             ext_rst,
   output logic             tmo_pulse,
   output logic             chip_rst_req,
   output logic             warm_rst_req,
   output logic             flag_to,
   output logic             flag_pd
);
   logic tick, clr_go, clr_part, clr_full, wrap;

   assign clr_part = clr_go | (cfg_en & halt_cmd);
   assign clr_full = cfg_en & ext_rst;

   wdog_tick_sel #(.DIV_BITS(DIV_BITS)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (wdog_src_e'(cfg_src)),
      .osc_tick (osc_tick),
      .halted   (halted),
      .tick     (tick)
   );

   wdog_clear_ctl u_clr (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cfg_en),
      .dual       (cfg_dual),
      .clr_single (clr_single),
      .clr_one    (clr_one),
      .clr_two    (clr_two),
      .ext_rst    (ext_rst),
      .clr_go     (clr_go)
   );

   wdog_chain #(
      .PRE_BITS  (PRE_BITS),
      .POST_BITS (POST_BITS),
      .TAP_LOW   (TAP_LOW),
      .SEL_W     (SEL_W)
   ) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_en),
      .tick     (tick),
      .sel      (cfg_tsel),
      .clr_part (clr_part),
      .clr_full (clr_full),
      .wrap     (wrap)
   );

   wdog_status u_stat (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (cfg_en),
      .halted       (halted),
      .wrap         (wrap),
      .clr_sw       (clr_go),
      .halt_cmd     (halt_cmd),
      .tmo_pulse    (tmo_pulse),
      .chip_rst_req (chip_rst_req),
      .warm_rst_req (warm_rst_req),
      .flag_to      (flag_to),
      .flag_pd      (flag_pd)
   );

   // R11
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (!tmo_pulse && $stable(flag_to) && $stable(flag_pd)));
endmodule

// File: tb/wdog_dualclr_tb.sv
module wdog_dualclr_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b1, cfg_src = 1'b0, cfg_dual = 1'b0;
   logic [1:0] cfg_tsel = 2'd0;
   logic       osc_tick = 1'b1, halted = 1'b0;
   logic       clr_single = 1'b0, clr_one = 1'b0, clr_two = 1'b0;
   logic       halt_cmd = 1'b0, ext_rst = 1'b0;
   logic       tmo_pulse, chip_rst_req, warm_rst_req, flag_to, flag_pd;

   wdog_dualclr u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src(cfg_src),
      .cfg_tsel(cfg_tsel), .cfg_dual(cfg_dual), .osc_tick(osc_tick),
      .halted(halted), .clr_single(clr_single), .clr_one(clr_one),
      .clr_two(clr_two), .halt_cmd(halt_cmd), .ext_rst(ext_rst),
      .tmo_pulse(tmo_pulse), .chip_rst_req(chip_rst_req),
      .warm_rst_req(warm_rst_req), .flag_to(flag_to), .flag_pd(flag_pd)
   );

   int cyc = 0;
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   typedef struct { int at; bit warm; } exp_t;
   exp_t sb[$];

   task automatic expect_tmo(input int at, input bit warm);
      exp_t e;
      e.at = at;
      e.warm = warm;
      sb.push_back(e);
   endtask

   // monitor: pops one expected time-out per observed pulse
   bit prev_tmo = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (tmo_pulse) begin
            check(!prev_tmo, "R7 pulse width", 2, 1);
            if (sb.size() == 0) begin
               check(1'b0, "R3 unexpected time-out", cyc, -1);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(cyc == e.at, "R3/R4 time-out cycle", cyc, e.at);
               check(chip_rst_req == !e.warm && warm_rst_req == e.warm,
                     "R8 reset kind", {chip_rst_req, warm_rst_req}, {!e.warm, e.warm});
            end
         end
         prev_tmo = tmo_pulse;
      end else begin
         prev_tmo = 1'b0;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_cyc(input int n);
      while (cyc != n) @(negedge clk);
   endtask

   // pulse the selected strobe for one cycle, starting at the current negedge
   task automatic strobe(input int which);
      case (which)
         0: clr_single = 1'b1;
         1: clr_one    = 1'b1;
         2: clr_two    = 1'b1;
         3: halt_cmd   = 1'b1;
         default: ext_rst = 1'b1;
      endcase
      @(negedge clk);
      clr_single = 1'b0; clr_one = 1'b0; clr_two = 1'b0;
      halt_cmd = 1'b0; ext_rst = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      check(1'b0, "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      // test A: R1, R3, R4, R5, R7, R9 in single mode
      do_reset();
      check(!flag_to && !flag_pd && !tmo_pulse && !chip_rst_req && !warm_rst_req,
            "R1 reset state", {flag_to, flag_pd, tmo_pulse, chip_rst_req, warm_rst_req}, 0);
      expect_tmo(8192, 1'b0);
      wait_cyc(8193);
      check(flag_to == 1'b1, "R7 flag_to set", flag_to, 1);
      check(flag_pd == 1'b0, "R7 flag_pd kept", flag_pd, 0);
      wait_cyc(10340);
      strobe(0);
      check(flag_to == 1'b0, "R5 clear drops flag_to", flag_to, 0);
      expect_tmo(18433, 1'b0);
      wait_cyc(18440);
      strobe(3);
      check(flag_pd == 1'b1 && flag_to == 1'b0, "R9 halt flags", {flag_pd, flag_to}, 2);
      strobe(1);
      check(flag_pd == 1'b1, "R5 clr_one ignored", flag_pd, 1);
      strobe(2);
      check(flag_pd == 1'b1, "R5 clr_two ignored", flag_pd, 1);
      strobe(0);
      check(flag_pd == 1'b0, "R5 single clear drops flag_pd", flag_pd, 0);

      // test B: R3 other taps
      cfg_tsel = 2'd1;
      do_reset();
      expect_tmo(16384, 1'b0);
      wait_cyc(16386);
      cfg_tsel = 2'd2;
      do_reset();
      expect_tmo(32768, 1'b0);
      wait_cyc(32770);
      cfg_tsel = 2'd0;

      // test C: R8 warm reset while halted, oscillator keeps counting (R10)
      halted = 1'b1;
      do_reset();
      expect_tmo(8192, 1'b1);
      wait_cyc(8193);
      check(flag_to == 1'b1, "R8 flag_to on warm time-out", flag_to, 1);
      halted = 1'b0;

      // test D: R2 and R10 instruction clock source with a halt stall
      cfg_src = 1'b1;
      osc_tick = 1'b0;
      do_reset();
      expect_tmo(33168, 1'b0);
      wait_cyc(1000);
      halted = 1'b1;
      wait_cyc(1400);
      halted = 1'b0;
      wait_cyc(33170);
      cfg_src = 1'b0;
      osc_tick = 1'b1;

      // test E: R11 disabled
      cfg_en = 1'b0;
      do_reset();
      wait_cyc(100);
      strobe(3);
      check(flag_pd == 1'b0, "R11 halt ignored when off", flag_pd, 0);
      strobe(4);
      wait_cyc(3000);
      check(!tmo_pulse && !flag_to, "R11 no time-out when off", {tmo_pulse, flag_to}, 0);
      cfg_en = 1'b1;
      expect_tmo(11192, 1'b0);
      wait_cyc(11194);

      // test F1: R6 dual-clear arming seen on flag_pd
      cfg_dual = 1'b1;
      do_reset();
      wait_cyc(10);
      strobe(3);
      check(flag_pd == 1'b1, "R9 halt sets flag_pd", flag_pd, 1);
      wait_cyc(20);
      strobe(0);
      check(flag_pd == 1'b1, "R6 clr_single ignored", flag_pd, 1);
      wait_cyc(30);
      strobe(1);
      check(flag_pd == 1'b1, "R6 clr_one alone", flag_pd, 1);
      wait_cyc(40);
      strobe(1);
      check(flag_pd == 1'b1, "R6 clr_one twice", flag_pd, 1);
      wait_cyc(50);
      strobe(2);
      check(flag_pd == 1'b0, "R6 pair completes", flag_pd, 0);
      wait_cyc(60);
      strobe(2);
      wait_cyc(70);
      strobe(3);
      check(flag_pd == 1'b1, "R6 clr_two held, halt sets flag_pd", flag_pd, 1);
      wait_cyc(90);
      strobe(1);
      check(flag_pd == 1'b0, "R6 armed clr_two pairs with clr_one", flag_pd, 0);
      wait_cyc(100);
      strobe(2);
      check(flag_pd == 1'b0, "R6 pair disarmed", flag_pd, 0);

      // test F2: R6 and R4 dual clear timing
      do_reset();
      wait_cyc(100);
      strobe(1);
      wait_cyc(2148);
      strobe(2);
      expect_tmo(10241, 1'b0);
      wait_cyc(10243);
      cfg_dual = 1'b0;

      // test G: R12 external reset keeps flags
      do_reset();
      wait_cyc(100);
      strobe(3);
      wait_cyc(5000);
      strobe(4);
      check(flag_pd == 1'b1, "R12 flags kept", flag_pd, 1);
      expect_tmo(13193, 1'b0);
      wait_cyc(13195);

      check(sb.size() == 0, "R7 all expected time-outs seen", sb.size(), 0);
      finish_run();
   end
endmodule